// File: doc/BRIEF.md
# Two-Pin External Interrupt Sense Controller

This block watches two external interrupt pins and turns activity on them into interrupt requests. Each pin has its own two-bit sense code. The code selects one of four conditions: the pin being low, any change of the pin, a falling transition or a rising transition. Every pin passes through a two-flop synchronizer. The synchronized value is then compared with the value from the cycle before, so edges are found between two registered samples and never on the raw pin.

In the three transition modes, a detected event sets a pending flag for that pin. The flag stays set until one of two things clears it: software writes a 1 to its bit, or the interrupt controller pulses that pin's acknowledge line. In low-level mode no flag is kept, and the request simply follows the synchronized low level. A pin's request reaches its output only when the global enable input and that pin's mask bit are both set. The sense codes, the mask bits and the pending flags are held in three registers. These registers sit on a simple synchronous bus, and reads return data one cycle after the request.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense register reads 0x00. Bits [1:0] hold pin 0's code and bits [3:2] hold pin 1's code. Bits [7:4] always read zero, whatever was written to them.
- R2: Sense codes are the same for both pins: 00 = low level, 01 = any change, 10 = falling transition, 11 = rising transition.
- R3: In low-level mode (00), irq_req follows the synchronized low level of the pin. It rises on the second clock edge after the pin falls, and it drops again once the pin returns high. No pending flag is set in this mode.
- R4: In a transition mode, a matching transition sets the pin's pending flag on the third clock edge after the pin changes. The flag reads back at bit i of the flag register (address 2).
- R5: In falling mode a rising transition does not set the flag, and in rising mode a falling transition does not set the flag. In any-change mode both directions set it.
- R6: Writing 1 to bit i of the flag register clears that pin's pending flag. Writing 0 leaves it unchanged.
- R7: A one-cycle pulse on irq_ack[i] clears pin i's pending flag.
- R8: irq_req[i] is high only while glob_en is high and mask bit i (address 1, bit i) is set. A pending flag is still recorded while its request is masked.
- R9: Register reads return data on the clock edge after the read request. Address 0 is the sense register, 1 the mask register and 2 the flag register. Address 3 reads zero. Mask and flag bits [7:2] read zero.
- R10: In a transition mode, a pulse that lasts two clock periods is caught and sets the pending flag.
- R11: When a flag is being set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read |
| glob_en | input | 1 | Global interrupt enable |
| pin_in | input | 2 | Asynchronous external interrupt pins |
| irq_ack | input | 2 | Per-pin acknowledge, clears the pending flag |
| irq_req | output | 2 | Per-pin gated interrupt request |

## Verification
The assertions assume that every asynchronous pin change is sampled by the synchronizer, and that no pin toggles faster than once per clock. The stimulus changes pins only on falling clock edges and holds each level for at least two cycles. Pins idle high after reset. Before each sense code is changed, the stimulus leaves the pins steady, so the reference model never has to resolve a transition that coincides with a mode switch.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned PIN_N     = 2;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned SENSE_W   = PIN_N * CODE_W;

  typedef enum logic [CODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] REG_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] REG_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_FLAG  = 2'd2;

  // Transition event between two registered samples for a given code.
  function automatic logic sense_event(input sense_e code, input logic prev, input logic cur);
    logic ev;
    case (code)
      SENSE_ANY:  ev = prev ^ cur;
      SENSE_FALL: ev = prev & ~cur;
      SENSE_RISE: ev = ~prev & cur;
      default:    ev = 1'b0;
    endcase
    return ev;
  endfunction

  // Level condition used only in low-level mode.
  function automatic logic level_active(input sense_e code, input logic cur);
    return (code == SENSE_LOW) && !cur;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= pin_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[LAST-1:0], pin_async};
      end
    end
  endgenerate

  assign pin_sync = chain_q[LAST];
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cur_i,
  input  sense_e mode_i,
  input  logic   sw_clr_i,
  input  logic   ack_i,
  output logic   evt_o,
  output logic   level_o,
  output logic   pend_o
);
  logic prev_q;
  logic pend_q;
  logic set_w;
  logic clr_w;

  assign evt_o   = sense_event(mode_i, prev_q, cur_i);
  assign level_o = level_active(mode_i, cur_i);
  assign set_w   = evt_o && (mode_i != SENSE_LOW);
  assign clr_w   = sw_clr_i || ack_i;

  // Previous sample tracks the current one every cycle, so a change of
  // code never compares against a stale sample.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= cur_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_w) pend_q <= 1'b1;
    else if (clr_w) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> pend_q);

  a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !set_w && pend_q) |=> !pend_q);

  a_r3_low_mode_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [PIN_N-1:0]   pend_i,
  output logic [SENSE_W-1:0] sense_o,
  output logic [PIN_N-1:0]   mask_o,
  output logic [PIN_N-1:0]   flag_clr_o
);
  logic [SENSE_W-1:0] sense_q;
  logic [PIN_N-1:0]   mask_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rdata_n;
  logic               wr_en;
  logic               rd_en;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (bus_addr == REG_SENSE) sense_q <= bus_wdata[SENSE_W-1:0];
      if (bus_addr == REG_MASK)  mask_q  <= bus_wdata[PIN_N-1:0];
    end
  end

  assign flag_clr_o = (wr_en && bus_addr == REG_FLAG) ? bus_wdata[PIN_N-1:0] : '0;

  always_comb begin
    rdata_n = '0;
    case (bus_addr)
      REG_SENSE: rdata_n[SENSE_W-1:0] = sense_q;
      REG_MASK:  rdata_n[PIN_N-1:0]   = mask_q;
      REG_FLAG:  rdata_n[PIN_N-1:0]   = pend_i;
      default:   rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
  assign sense_o   = sense_q;
  assign mask_o    = mask_q;

  a_r1_upper_sense_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == REG_SENSE) |=> (bus_rdata[DATA_W-1:SENSE_W] == '0));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == 2'd3) |=> (bus_rdata == '0));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              glob_en,
  input  logic [PIN_N-1:0]  pin_in,
  input  logic [PIN_N-1:0]  irq_ack,
  output logic [PIN_N-1:0]  irq_req
);
  logic [SENSE_W-1:0] sense_w;
  logic [PIN_N-1:0]   mask_w;
  logic [PIN_N-1:0]   flag_clr_w;
  logic [PIN_N-1:0]   pin_sync_w;
  logic [PIN_N-1:0]   evt_w;
  logic [PIN_N-1:0]   level_w;
  logic [PIN_N-1:0]   pend_w;
  logic [PIN_N-1:0]   raw_req_w;

  irq_regbus u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pend_i     (pend_w),
    .sense_o    (sense_w),
    .mask_o     (mask_w),
    .flag_clr_o (flag_clr_w)
  );

  generate
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
      sense_e mode_w;
      assign mode_w = sense_e'(sense_w[i*CODE_W +: CODE_W]);

      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in[i]),
        .pin_sync  (pin_sync_w[i])
      );

      irq_sense_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_i    (pin_sync_w[i]),
        .mode_i   (mode_w),
        .sw_clr_i (flag_clr_w[i]),
        .ack_i    (irq_ack[i]),
        .evt_o    (evt_w[i]),
        .level_o  (level_w[i]),
        .pend_o   (pend_w[i])
      );

      assign raw_req_w[i] = (mode_w == SENSE_LOW) ? level_w[i] : pend_w[i];
      assign irq_req[i]   = raw_req_w[i] && mask_w[i] && glob_en;

      a_r8_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[i] |-> (glob_en && mask_w[i]));

      a_r3_low_req_tracks_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == SENSE_LOW && pin_sync_w[i]) |-> !irq_req[i]);
    end
  endgenerate
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       glob_en;
  logic [1:0] pin_in, irq_ack, irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glob_en(glob_en), .pin_in(pin_in), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // Flag register write-one clears every pin; pins back to idle high.
  task automatic settle();
    pin_in = 2'b11; cyc(4); wr(2'd2, 8'h03);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 req after reset", {6'd0, irq_req}, 8'h00);
    rd(2'd0, d); check("R1 sense reset", d, 8'h00);
    rd(2'd1, d); check("R9 mask reset", d, 8'h00);
    rd(2'd2, d); check("R9 flag reset", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R1 upper sense bits zero", d, 8'h0F);
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R9 mask upper zero", d, 8'h03);
    rd(2'd3, d); check("R9 unmapped reads zero", d, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_low();
    logic [7:0] d;
    wr(2'd0, 8'h00); wr(2'd1, 8'h03); glob_en = 1;
    pin_in[0] = 0;
    cyc(1); check("R3 latency edge 1", {6'd0, irq_req}, 8'h00);
    cyc(1); check("R3 latency edge 2", {6'd0, irq_req}, 8'h01);
    cyc(3); rd(2'd2, d); check("R3 no flag in low mode", d, 8'h00);
    pin_in[0] = 1; cyc(2); check("R3 req drops on high", {6'd0, irq_req}, 8'h00);
  endtask

  task automatic t_gate();
    wr(2'd0, 8'h00); wr(2'd1, 8'h03);
    pin_in[0] = 0; glob_en = 0; cyc(3);
    check("R8 global disable", {6'd0, irq_req}, 8'h00);
    glob_en = 1; wr(2'd1, 8'h02); cyc(1);
    check("R8 mask off", {6'd0, irq_req}, 8'h00);
    wr(2'd1, 8'h01); cyc(1);
    check("R8 both set", {6'd0, irq_req}, 8'h01);
    pin_in[0] = 1; cyc(3);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h02); wr(2'd1, 8'h03); glob_en = 1;
    pin_in[0] = 0;
    cyc(2); check("R4 flag not yet at edge 2", {6'd0, irq_req}, 8'h00);
    cyc(1); check("R4 flag set at edge 3", {6'd0, irq_req}, 8'h01);
    rd(2'd2, d); check("R2 falling code 10", d, 8'h01);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R6 write zero keeps flag", d, 8'h01);
    wr(2'd2, 8'h01); rd(2'd2, d); check("R6 write one clears", d, 8'h00);
    pin_in[0] = 1; cyc(4); rd(2'd2, d); check("R5 rise ignored in fall mode", d, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h0C); wr(2'd1, 8'h03);
    pin_in[1] = 0; cyc(4); rd(2'd2, d); check("R5 fall ignored in rise mode", d, 8'h00);
    pin_in[1] = 1; cyc(4); rd(2'd2, d); check("R2 rising code 11 pin1", d, 8'h02);
    check("R4 req pin1", {6'd0, irq_req}, 8'h02);
  endtask

  task automatic t_any();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h01);
    pin_in[0] = 0; cyc(4); rd(2'd2, d); check("R5 any mode fall", d, 8'h01);
    wr(2'd2, 8'h01);
    pin_in[0] = 1; cyc(4); rd(2'd2, d); check("R5 any mode rise", d, 8'h01);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h02); wr(2'd1, 8'h03);
    pin_in[0] = 0; cyc(4);
    check("R7 pending before ack", {6'd0, irq_req}, 8'h01);
    irq_ack = 2'b01; cyc(1); irq_ack = 2'b00;
    check("R7 ack clears", {6'd0, irq_req}, 8'h00);
    rd(2'd2, d); check("R7 flag after ack", d, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h02); wr(2'd1, 8'h00);
    pin_in[0] = 0; cyc(4);
    check("R8 masked no req", {6'd0, irq_req}, 8'h00);
    rd(2'd2, d); check("R8 masked flag recorded", d, 8'h01);
    wr(2'd1, 8'h01); cyc(1);
    check("R8 unmask shows req", {6'd0, irq_req}, 8'h01);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h03);
    pin_in[0] = 1'b0; cyc(4); wr(2'd2, 8'h03);
    pin_in[0] = 1'b1; cyc(2); pin_in[0] = 1'b0; cyc(4);
    rd(2'd2, d); check("R10 two-cycle pulse caught", d, 8'h01);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    settle(); wr(2'd0, 8'h02); wr(2'd1, 8'h01);
    pin_in[0] = 0; cyc(2);
    irq_ack = 2'b01; cyc(1); irq_ack = 2'b00;
    rd(2'd2, d); check("R11 set wins over ack", d, 8'h01);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    glob_en = 0; pin_in = 2'b11; irq_ack = 2'b00;
    cyc(4); rst_n = 1; cyc(1);
    t_reset();
    t_regs();
    t_low();
    t_gate();
    t_fall();
    t_rise();
    t_any();
    t_ack();
    t_masked();
    t_pulse();
    t_set_wins();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule